// File: doc/BRIEF.md
# Turn-Signal Tail-Light Sequencer

This block drives three tail lamps on each side of a vehicle from three request lines: turn left, turn right and hazard. It is a clocked Moore machine with eight states held in three flip-flops. A turn request starts a chase on that side. One lamp lights first, then two, then all three, and then the side goes dark. A hazard request, or a left and a right request together, lights all six lamps for one clock and then returns to dark. Holding the request therefore makes the lamps flash.

A hazard request raised while a turn chase is running ends the chase. The machine goes to all-lamps-on on the next clock. The clock is expected to run at the flash rate already; dividing the clock down and driving the lamps happen outside the block. Inside, two state bits step through Gray order (00, 01, 11, 10) for each chase, and a third bit selects the side. Dark is code 000, and all-lamps-on is code 100.

Top module: `tail_light_seq`

## Requirements
- R1: While `rst_n` is low, the machine is in the dark state and all six lamp outputs are 0. This holds when reset is asserted in the middle of a chase as well.
- R2: In the dark state with no request asserted, the machine stays dark on the next clock.
- R3: In the dark state with only the left request high, the next clock gives `lamp_left`=001 and `lamp_right`=000. Bit 0 is the innermost lamp.
- R4: In the dark state with only the right request high, the next clock gives `lamp_right`=001 and `lamp_left`=000.
- R5: In the dark state, hazard high or left and right both high gives all six lamps on at the next clock. Every one of the eight input combinations in the dark state selects exactly one successor.
- R6: With hazard low, the left chase shows `lamp_left` values 001, 011 and 111 on successive clocks and then goes dark. The turn inputs do not alter a chase once it has begun.
- R7: With hazard low, the right chase shows `lamp_right` values 001, 011 and 111 and then goes dark. At no time is only part of both sides lit; both sides are lit only when all six lamps are on.
- R8: Hazard high in the first or second step of either chase gives all six lamps on at the next clock.
- R9: The third step of either chase and the all-lamps-on state go dark on the next clock, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the flash step rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_req | input | 1 | Left turn request |
| right_req | input | 1 | Right turn request |
| haz_req | input | 1 | Hazard request |
| lamp_left | output | 3 | Left lamps, bit 0 innermost |
| lamp_right | output | 3 | Right lamps, bit 0 innermost |

## Verification
The bench tries all eight input combinations from the dark state. A machine with overlapping or missing transition terms would light the wrong side, or light nothing, for some combination such as all three requests high. It raises hazard at each of the four early chase steps. A design that lets the chase finish would show two or three side lamps where all six should be lit. It also holds requests high through the third step and through all-lamps-on, where a machine that reads its inputs there would skip the dark cycle and stop flashing. Finally, it asserts reset in the middle of a chase, where a machine that kept its step would leave lamps lit.

// File: rtl/tail_light_seq.sv
module tail_light_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       left_req,
  input  logic       right_req,
  input  logic       haz_req,
  output logic [2:0] lamp_left,
  output logic [2:0] lamp_right
);

  typedef enum logic [2:0] {
    S_DARK = 3'b000,
    S_L1   = 3'b001,
    S_L2   = 3'b011,
    S_L3   = 3'b010,
    S_ALL  = 3'b100,
    S_R1   = 3'b101,
    S_R2   = 3'b111,
    S_R3   = 3'b110
  } state_t;

  state_t state, state_nx;

  wire go_all   = haz_req | (left_req & right_req);
  wire go_left  = left_req & ~right_req & ~haz_req;
  wire go_right = right_req & ~left_req & ~haz_req;
  wire early    = (state == S_L1) | (state == S_L2) |
                  (state == S_R1) | (state == S_R2);

  always_comb begin
    state_nx = S_DARK;
    unique case (state)
      S_DARK: begin
        if (go_all)        state_nx = S_ALL;
        else if (go_left)  state_nx = S_L1;
        else if (go_right) state_nx = S_R1;
        else               state_nx = S_DARK;
      end
      S_L1: state_nx = haz_req ? S_ALL : S_L2;
      S_L2: state_nx = haz_req ? S_ALL : S_L3;
      S_R1: state_nx = haz_req ? S_ALL : S_R2;
      S_R2: state_nx = haz_req ? S_ALL : S_R3;
      S_L3, S_R3, S_ALL: state_nx = S_DARK;
      default: state_nx = S_DARK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_DARK;
    else        state <= state_nx;

  // Gray step: 01 -> one lamp, 11 -> two, 10 -> three
  logic [2:0] chase;
  always_comb
    unique case (state[1:0])
      2'b01:   chase = 3'b001;
      2'b11:   chase = 3'b011;
      2'b10:   chase = 3'b111;
      default: chase = 3'b000;
    endcase

  assign lamp_left  = (state == S_ALL) ? 3'b111 : (state[2] ? 3'b000 : chase);
  assign lamp_right = (state == S_ALL) ? 3'b111 : (state[2] ? chase  : 3'b000);

  p_dark_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DARK && !left_req && !right_req && !haz_req) |=> state == S_DARK);

  p_all_from_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DARK && (haz_req || (left_req && right_req))) |=>
      (lamp_left == 3'b111 && lamp_right == 3'b111));

  p_gray_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (early && !haz_req) |=> $countones(state ^ $past(state)) == 1);

  p_sides_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_left != 3'b000 && lamp_right != 3'b000) |->
      (lamp_left == 3'b111 && lamp_right == 3'b111));

  p_hazard_cuts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (early && haz_req) |=> (lamp_left == 3'b111 && lamp_right == 3'b111));

  p_back_to_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_L3 || state == S_R3 || state == S_ALL) |=>
      (lamp_left == 3'b000 && lamp_right == 3'b000));

endmodule

// File: tb/tail_light_seq_bench.sv
module tail_light_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic left_req = 1'b0, right_req = 1'b0, haz_req = 1'b0;
  logic [2:0] lamp_left, lamp_right;
  int runs = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tail_light_seq u_tail_light_seq (
    .clk(clk), .rst_n(rst_n), .left_req(left_req), .right_req(right_req),
    .haz_req(haz_req), .lamp_left(lamp_left), .lamp_right(lamp_right)
  );

  // {left, right, haz, expected left lamps, expected right lamps, tag}
  localparam int NV = 41;
  localparam logic [12:0] VEC [NV] = '{
    {3'b000, 3'b000, 3'b000, 4'd2},  // R2 stays dark
    {3'b100, 3'b001, 3'b000, 4'd3},  // R3 left start
    {3'b000, 3'b011, 3'b000, 4'd6},  // R6
    {3'b000, 3'b111, 3'b000, 4'd6},  // R6
    {3'b000, 3'b000, 3'b000, 4'd6},  // R6 ends dark
    {3'b010, 3'b000, 3'b001, 4'd4},  // R4 right start
    {3'b000, 3'b000, 3'b011, 4'd7},  // R7
    {3'b000, 3'b000, 3'b111, 4'd7},  // R7
    {3'b000, 3'b000, 3'b000, 4'd7},  // R7 ends dark
    {3'b001, 3'b111, 3'b111, 4'd5},  // R5 hazard
    {3'b001, 3'b000, 3'b000, 4'd9},  // R9 flash off
    {3'b110, 3'b111, 3'b111, 4'd5},  // R5 both sides
    {3'b110, 3'b000, 3'b000, 4'd9},  // R9
    {3'b100, 3'b001, 3'b000, 4'd3},  // R3
    {3'b001, 3'b111, 3'b111, 4'd8},  // R8 cut at L1
    {3'b000, 3'b000, 3'b000, 4'd9},  // R9
    {3'b010, 3'b000, 3'b001, 4'd4},  // R4
    {3'b010, 3'b000, 3'b011, 4'd7},  // R7 held request ignored
    {3'b011, 3'b111, 3'b111, 4'd8},  // R8 cut at R2
    {3'b000, 3'b000, 3'b000, 4'd9},  // R9
    {3'b100, 3'b001, 3'b000, 4'd3},  // R3
    {3'b110, 3'b011, 3'b000, 4'd6},  // R6 both turns ignored mid-chase
    {3'b101, 3'b111, 3'b111, 4'd8},  // R8 cut at L2
    {3'b000, 3'b000, 3'b000, 4'd9},  // R9
    {3'b010, 3'b000, 3'b001, 4'd4},  // R4
    {3'b011, 3'b111, 3'b111, 4'd8},  // R8 cut at R1
    {3'b000, 3'b000, 3'b000, 4'd9},  // R9
    {3'b100, 3'b001, 3'b000, 4'd3},  // R3
    {3'b000, 3'b011, 3'b000, 4'd6},  // R6
    {3'b000, 3'b111, 3'b000, 4'd6},  // R6
    {3'b111, 3'b000, 3'b000, 4'd9},  // R9 L3 ignores inputs
    {3'b111, 3'b111, 3'b111, 4'd5},  // R5 all requests
    {3'b000, 3'b000, 3'b000, 4'd9},  // R9
    {3'b010, 3'b000, 3'b001, 4'd4},  // R4
    {3'b000, 3'b000, 3'b011, 4'd7},  // R7
    {3'b000, 3'b000, 3'b111, 4'd7},  // R7
    {3'b101, 3'b000, 3'b000, 4'd9},  // R9 R3 ignores inputs
    {3'b101, 3'b111, 3'b111, 4'd5},  // R5 hazard with left
    {3'b011, 3'b000, 3'b000, 4'd9},  // R9
    {3'b011, 3'b111, 3'b111, 4'd5},  // R5 hazard with right
    {3'b000, 3'b000, 3'b000, 4'd9}   // R9
  };

  task automatic check(input string tag, input logic [2:0] el, input logic [2:0] er);
    runs++;
    if (lamp_left !== el || lamp_right !== er) begin
      fails++;
      $display("FAIL %s: lamps L=%b R=%b, expected L=%b R=%b",
               tag, lamp_left, lamp_right, el, er);
    end
  endtask

  task automatic step(input logic l, input logic r, input logic h);
    @(negedge clk);
    left_req = l; right_req = r; haz_req = h;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; left_req = 1'b0; right_req = 1'b0; haz_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset", 3'b000, 3'b000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10]);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][9:7], VEC[i][6:4]);
    end

    // R5: every IDLE input combination is claimed by exactly one transition
    for (int c = 0; c < 8; c++) begin
      int claims;
      logic [2:0] el, er;
      logic l, r, h;
      l = c[2]; r = c[1]; h = c[0];
      claims = 0; el = 3'b000; er = 3'b000;
      if (h || (l && r))   begin claims++; el = 3'b111; er = 3'b111; end
      if (l && !r && !h)   begin claims++; el = 3'b001; end
      if (r && !l && !h)   begin claims++; er = 3'b001; end
      if (!l && !r && !h)  claims++;
      runs++;
      if (claims != 1) begin
        fails++;
        $display("FAIL R5: combo %b claimed %0d times, expected 1", c[2:0], claims);
      end
      do_reset();
      step(l, r, h);
      check($sformatf("R5 idle combo %b", c[2:0]), el, er);
    end

    // R1: reset during a chase
    do_reset();
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check("R6 before reset", 3'b011, 3'b000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid chase", 3'b000, 3'b000);
    @(posedge clk); #1;
    check("R1 reset held", 3'b000, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    check("R2 dark after reset", 3'b000, 3'b000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule